// File: doc/BRIEF.md
# Overlay/Underlay Pixel Color Selector

This block sits in front of a color palette lookup and decides, pixel by pixel, which color index reaches it. Each pixel brings three things: a primary color index, a 4-bit overlay nibble, and a split-mode control bit taken from a command register. The block always returns a single color index and a 2-bit source tag. The tag reports whether the index came from the primary input, the overlay, or the underlay.

In normal mode the overlay wins whenever its nibble is non-zero. In split mode the top bit of the nibble picks the meaning of the low three bits. With the top bit set, those bits are an overlay color that wins over the primary input. With the top bit clear, they are an underlay color that shows only where the primary index is zero. Overlay and underlay colors are placed in reserved index ranges above the primary range, so they can never alias a primary palette entry.

The decision is registered once. A pixel-valid bit travels with the data. While no valid pixel is presented, the registered index and tag hold their previous values.

Top module: `ovl_underlay_sel`

## Requirements
- R1: While reset is high and after the first clock edge with reset high, out_valid is 0, out_index is 0 and out_src is 2'b00.
- R2: In normal mode (split_mode=0), a valid pixel with a non-zero overlay nibble gives out_src=2'b01 and out_index = 2^PIX_W + 16 + nibble, whatever the primary index is.
- R3: In normal mode, a valid pixel with overlay nibble 0 gives out_src=2'b00 and out_index equal to the primary index (zero-extended, so the top bit is 0).
- R4: In split mode (split_mode=1), a valid pixel whose nibble has bit 3 set gives out_src=2'b01 and out_index = 2^PIX_W + 16 + nibble (offsets 24..31 above 2^PIX_W), whatever the primary index is.
- R5: In split mode, a valid pixel whose nibble has bit 3 clear and whose primary index is zero gives out_src=2'b10 and out_index = 2^PIX_W + nibble[2:0]. Underlay code 0 is included.
- R6: In split mode, a valid pixel whose nibble has bit 3 clear and whose primary index is non-zero gives out_src=2'b00 and out_index equal to the primary index.
- R7: All results appear exactly one clock after the inputs are sampled, and out_valid is in_valid delayed by one clock. split_mode is sampled per pixel along with the data.
- R8: A clock edge with in_valid=0 leaves out_index and out_src unchanged, whatever the other inputs are.
- R9: out_src never takes the value 2'b11. The three index ranges never overlap: primary below 2^PIX_W, underlay at 2^PIX_W+0..7, overlay at 2^PIX_W+16..31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pixel present on this cycle |
| split_mode | input | 1 | 1 selects split overlay/underlay mode |
| ovl | input | 4 | Overlay/underlay nibble |
| pix | input | PIX_W (8) | Primary color index |
| out_valid | output | 1 | Registered pixel-valid |
| out_index | output | PIX_W+1 (9) | Selected palette index |
| out_src | output | 2 | Source tag: 00 primary, 01 overlay, 10 underlay |

## Verification
Every result is due exactly one clock after the edge that samples the pixel. This applies to the index, the tag and the valid flag alike, and no output takes two cycles. The bench drives each pixel on a falling edge and lets the reference model update at the following rising edge. It then compares all three outputs at the next falling edge, so each comparison lands in the cycle where the register has just loaded. Idle cycles with scrambled inputs are compared in the same way, which shows the held values at the ports.

// File: rtl/ovl_sel_pkg.sv
package ovl_sel_pkg;

    localparam int NIB_W      = 4;
    localparam int CODE_W     = 3;
    localparam int OVL_OFFSET = 16;

    typedef enum logic [1:0] {
        SRC_PRIMARY  = 2'b00,
        SRC_OVERLAY  = 2'b01,
        SRC_UNDERLAY = 2'b10
    } src_e;

    typedef struct packed {
        logic              valid;
        logic              split;
        logic [NIB_W-1:0]  nib;
    } pix_ctl_t;

    // Top nibble bit marks an overlay colour in split mode
    function automatic logic nib_is_overlay(input logic [NIB_W-1:0] n);
        return n[NIB_W-1];
    endfunction

    function automatic logic [CODE_W-1:0] nib_code(input logic [NIB_W-1:0] n);
        return n[CODE_W-1:0];
    endfunction

endpackage

// File: rtl/ovl_sel_classify.sv
module ovl_sel_classify
    import ovl_sel_pkg::*;
(
    input  logic             split_mode,
    input  logic [NIB_W-1:0] nib,
    input  logic             pix_zero,
    output src_e             src
);
    logic nib_zero;

    assign nib_zero = (nib == '0);

    always_comb begin
        if (!split_mode) begin
            src = nib_zero ? SRC_PRIMARY : SRC_OVERLAY;
        end else if (nib_is_overlay(nib)) begin
            src = SRC_OVERLAY;
        end else if (pix_zero) begin
            src = SRC_UNDERLAY;
        end else begin
            src = SRC_PRIMARY;
        end
    end
endmodule

// File: rtl/ovl_sel_indexmap.sv
module ovl_sel_indexmap
    import ovl_sel_pkg::*;
#(
    parameter int PIX_W = 8,
    localparam int IDX_W = PIX_W + 1
)(
    input  src_e             src,
    input  logic [NIB_W-1:0] nib,
    input  logic [PIX_W-1:0] pix,
    output logic [IDX_W-1:0] idx
);
    localparam int PAD_OVL = PIX_W - 1 - NIB_W;
    localparam int PAD_UND = PIX_W - CODE_W;

    logic [IDX_W-1:0] ovl_idx;
    logic [IDX_W-1:0] und_idx;
    logic [IDX_W-1:0] pri_idx;

    // Reserved region sits above the primary range
    assign ovl_idx = {1'b1, {PAD_OVL{1'b0}}, 1'b1, nib};
    assign und_idx = {1'b1, {PAD_UND{1'b0}}, nib_code(nib)};
    assign pri_idx = {1'b0, pix};

    always_comb begin
        unique case (src)
            SRC_OVERLAY:  idx = ovl_idx;
            SRC_UNDERLAY: idx = und_idx;
            default:      idx = pri_idx;
        endcase
    end
endmodule

// File: rtl/ovl_sel_stage.sv
module ovl_sel_stage
    import ovl_sel_pkg::*;
#(
    parameter int IDX_W = 9
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             d_valid,
    input  src_e             d_src,
    input  logic [IDX_W-1:0] d_idx,
    output logic             q_valid,
    output src_e             q_src,
    output logic [IDX_W-1:0] q_idx
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid <= 1'b0;
            q_src   <= SRC_PRIMARY;
            q_idx   <= '0;
        end else begin
            q_valid <= d_valid;
            if (d_valid) begin
                q_src <= d_src;
                q_idx <= d_idx;
            end
        end
    end
endmodule

// File: rtl/ovl_underlay_sel.sv
module ovl_underlay_sel
    import ovl_sel_pkg::*;
#(
    parameter int PIX_W = 8,
    localparam int IDX_W = PIX_W + 1
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             split_mode,
    input  logic [3:0]       ovl,
    input  logic [PIX_W-1:0] pix,
    output logic             out_valid,
    output logic [PIX_W:0]   out_index,
    output logic [1:0]       out_src
);
    pix_ctl_t         ctl;
    src_e             dec_src;
    logic [IDX_W-1:0] dec_idx;
    src_e             reg_src;

    assign ctl = '{valid: in_valid, split: split_mode, nib: ovl};

    ovl_sel_classify u_classify (
        .split_mode (ctl.split),
        .nib        (ctl.nib),
        .pix_zero   (pix == '0),
        .src        (dec_src)
    );

    ovl_sel_indexmap #(.PIX_W(PIX_W)) u_map (
        .src (dec_src),
        .nib (ctl.nib),
        .pix (pix),
        .idx (dec_idx)
    );

    ovl_sel_stage #(.IDX_W(IDX_W)) u_stage (
        .clk     (clk),
        .rst     (rst),
        .d_valid (ctl.valid),
        .d_src   (dec_src),
        .d_idx   (dec_idx),
        .q_valid (out_valid),
        .q_src   (reg_src),
        .q_idx   (out_index)
    );

    assign out_src = reg_src;
endmodule

// File: rtl/ovl_sel_chk.sv
module ovl_sel_chk #(
    parameter int PIX_W = 8
)(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             split_mode,
    input logic [3:0]       ovl,
    input logic [PIX_W-1:0] pix,
    input logic             out_valid,
    input logic [PIX_W:0]   out_index,
    input logic [1:0]       out_src
);
    localparam int BASE = 1 << PIX_W;

    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (!out_valid && out_index == '0 && out_src == 2'b00)); // R1
    AST_NORMAL_OVERLAY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !split_mode && ovl != 4'd0) |=>
        (out_src == 2'b01 && int'(out_index) == BASE + 16 + int'($past(ovl)))); // R2
    AST_NORMAL_PRIMARY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !split_mode && ovl == 4'd0) |=>
        (out_src == 2'b00 && int'(out_index) == int'($past(pix)))); // R3
    AST_SPLIT_OVERLAY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && split_mode && ovl[3]) |=>
        (out_src == 2'b01 && int'(out_index) == BASE + 16 + int'($past(ovl)))); // R4
    AST_SPLIT_UNDERLAY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && split_mode && !ovl[3] && pix == '0) |=>
        (out_src == 2'b10 && int'(out_index) == BASE + int'($past(ovl[2:0])))); // R5
    AST_SPLIT_PRIMARY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && split_mode && !ovl[3] && pix != '0) |=>
        (out_src == 2'b00 && int'(out_index) == int'($past(pix)))); // R6
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R7
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_index) && $stable(out_src))); // R8
    AST_TAG_LEGAL: assert property (@(posedge clk) disable iff (rst) out_src != 2'b11); // R9
    AST_RANGE_MATCH: assert property (@(posedge clk) disable iff (rst)
        (out_src == 2'b00 && int'(out_index) < BASE) ||
        (out_src == 2'b10 && int'(out_index) >= BASE && int'(out_index) < BASE + 8) ||
        (out_src == 2'b01 && int'(out_index) >= BASE + 16 && int'(out_index) < BASE + 32)); // R9
endmodule

bind ovl_underlay_sel ovl_sel_chk #(.PIX_W(PIX_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .split_mode (split_mode),
    .ovl        (ovl),
    .pix        (pix),
    .out_valid  (out_valid),
    .out_index  (out_index),
    .out_src    (out_src)
);

// File: tb/ovl_underlay_sel_tb_top.sv
module ovl_underlay_sel_tb_top;
    localparam int PIX_W = 8;
    localparam int BASE  = 1 << PIX_W;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic             split_mode = 1'b0;
    logic [3:0]       ovl = 4'd0;
    logic [PIX_W-1:0] pix = '0;
    logic             out_valid;
    logic [PIX_W:0]   out_index;
    logic [1:0]       out_src;

    int n_cmp  = 0;
    int n_bad  = 0;
    bit done   = 0;

    int    exp_valid = 0;
    int    exp_idx   = 0;
    int    exp_src   = 0;
    string exp_req   = "R1";

    always #5 clk = ~clk;

    ovl_underlay_sel #(.PIX_W(PIX_W)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .split_mode(split_mode),
        .ovl(ovl), .pix(pix), .out_valid(out_valid), .out_index(out_index),
        .out_src(out_src)
    );

    // Behavioural reference: the value due one clock after sampling
    task automatic model_edge();
        int n;
        int p;
        n = int'(ovl);
        p = int'(pix);
        if (rst) begin
            exp_valid = 0; exp_idx = 0; exp_src = 0; exp_req = "R1";
        end else begin
            exp_valid = in_valid ? 1 : 0;
            if (!in_valid) begin
                exp_req = "R8";
            end else if (split_mode == 1'b0) begin
                if (n != 0) begin exp_src = 1; exp_idx = BASE + 16 + n; exp_req = "R2"; end
                else        begin exp_src = 0; exp_idx = p;            exp_req = "R3"; end
            end else if (n >= 8) begin
                exp_src = 1; exp_idx = BASE + 16 + n; exp_req = "R4";
            end else if (p == 0) begin
                exp_src = 2; exp_idx = BASE + n; exp_req = "R5";
            end else begin
                exp_src = 0; exp_idx = p; exp_req = "R6";
            end
        end
    endtask

    task automatic compare();
        bit bad = 0;
        n_cmp++;
        if (int'(out_valid) != exp_valid) begin
            bad = 1;
            $display("FAIL R7 (%s) out_valid actual=%0d expected=%0d", exp_req, out_valid, exp_valid);
        end
        if (int'(out_index) != exp_idx) begin
            bad = 1;
            $display("FAIL %s out_index actual=%0d expected=%0d", exp_req, out_index, exp_idx);
        end
        if (int'(out_src) != exp_src) begin
            bad = 1;
            $display("FAIL %s out_src actual=%0d expected=%0d", exp_req, out_src, exp_src);
        end
        if (out_src == 2'b11) begin
            bad = 1;
            $display("FAIL R9 out_src actual=3 expected=0..2");
        end
        if (bad) n_bad++;
    endtask

    // Called on a falling edge: drive, wait for capture, compare
    task automatic step(input bit v, input bit m, input int o, input int p);
        in_valid   = v;
        split_mode = m;
        ovl        = 4'(o);
        pix        = PIX_W'(p);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    initial begin
        @(negedge clk);
        step(1, 1, 15, 77);             // R1: inputs ignored during reset
        step(1, 0, 3, 5);               // R1
        rst = 1'b0;
        // R3 and R2: normal mode, every nibble, several primaries
        for (int o = 0; o < 16; o++) begin
            step(1, 0, o, 0);
            step(1, 0, o, 1);
            step(1, 0, o, 255);
            step(1, 0, o, 128 + o);
        end
        // R4, R5, R6: split mode, every nibble
        for (int o = 0; o < 16; o++) begin
            step(1, 1, o, 0);
            step(1, 1, o, 1);
            step(1, 1, o, 255);
            step(1, 1, o, 0);
        end
        // R8: idle cycles with scrambled inputs hold the last result
        step(1, 1, 5, 0);
        for (int k = 0; k < 6; k++) step(0, k % 2, 15 - k, 200 + k);
        step(1, 0, 9, 40);
        step(0, 1, 2, 0);
        step(0, 0, 0, 3);
        // R7: mode toggles every pixel
        for (int k = 0; k < 20; k++) step(1, k % 2, 3, k % 3);
        // mid-stream reset then recovery (R1)
        rst = 1'b1;
        step(1, 1, 12, 9);
        rst = 1'b0;
        step(1, 1, 0, 0);
        // random mix of all cases (R9 range/tag checks on every cycle)
        for (int k = 0; k < 3000; k++) begin
            int pr;
            pr = ($urandom % 4 == 0) ? 0 : int'($urandom % 256);
            step(($urandom % 5) != 0, $urandom % 2, int'($urandom % 16), pr);
        end
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule